// File: doc/BRIEF.md
# Program-Mode Memory Target Controller

This block is the device-side logic that runs while a part sits in its program-memory write/verify state. A programmer drives a 4-bit mode code, a slow clock pin and two 4-bit data ports. The block has no address pins. It keeps an internal address counter that moves forward one location for every four rising edges on the clock pin. The mode code picks one of four operations: clear the address, write the byte on the data ports, drive the stored byte back out for verify, or hold with the ports released.

The storage is a behavioural byte array. Its erased value is 0xFF, and programming can only clear bits, so each write ANDs the incoming byte into the stored one. The counter stops at the last location and raises a sticky overflow flag instead of wrapping back to zero. The full part uses `DEPTH` = 8064, which makes the last address 0x1F7F. The default is smaller so that elaboration stays light.

Top module: `prom_prog_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it is released, the address is 0, `addr_ovf_o` is 0, `dat_oe_o` is 0, both data outputs are 0, and every location reads 0xFF.
- R2: `mode_i` is decoded with bit n equal to mode pin n. `4'b0101` means clear, `4'b1110` means write, `4'b1100` means verify. Any code with bits 0, 2 and 3 high means inhibit.
- R3: In clear mode the address, the edge divider and the overflow flag all return to 0 on the next clock. This takes priority over a fourth clock-pin edge that arrives in the same cycle. After a clear, four fresh edges are needed before the next step.
- R4: `x1_i` is sampled on `clk_i`. A rising edge is a high sample that follows a low one. The fourth rising edge counted since the last step or clear moves the address forward by one, in every mode except clear. No other event changes the address.
- R5: When a fourth edge arrives at address `DEPTH-1`, the address stays there and `addr_ovf_o` goes to 1. The flag stays set until a clear or a reset.
- R6: In verify mode `dat_oe_o` is 1. The stored byte at the current address is driven with bits 3:0 on `dat_lo_o` and bits 7:4 on `dat_hi_o`. A new address's byte appears in the cycle after the step edge.
- R7: In write mode the data outputs are released. On each clock, the stored byte at the current address becomes its old value ANDed with `{dat_hi_i, dat_lo_i}`. If a step edge falls in the same cycle, the write goes to the address held before the step.
- R8: In inhibit mode and for any code not listed in R2, no write takes place, `dat_oe_o` is 0 and both data outputs are 0.
- R9: A stored bit that has been programmed to 0 never returns to 1. A write of 0xFF leaves the stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x1_i | input | 1 | Address-stepping clock pin, sampled on clk_i |
| mode_i | input | 4 | Mode pins, bit n is mode pin n |
| dat_lo_i | input | 4 | Write data, low nibble |
| dat_hi_i | input | 4 | Write data, high nibble |
| dat_lo_o | output | 4 | Verify data, low nibble |
| dat_hi_o | output | 4 | Verify data, high nibble |
| dat_oe_o | output | 1 | Data ports driven (verify) |
| addr_ovf_o | output | 1 | Sticky address-counter saturation flag |

## Verification
Two pairs of events can land in one cycle. A clear can meet the fourth edge of a step, and a write can meet the fourth edge of a step. Both pairs are produced on purpose: three edges are counted, and then the clear code or the write code is presented in the same cycle as the fourth rising edge. The outcome is judged from the port side. A later verify walk shows whether the address stepped, and which location took the written byte, by comparing the readback against a bench model that applies the write before the step and gives the clear priority over the step. Random mode, edge and data traffic then produces these pairings again at random.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;
  typedef enum logic [1:0] {
    OP_INHIBIT = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_VERIFY  = 2'd3
  } prom_op_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NIBBLE_W = 4;
endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
  import prom_prog_pkg::*;
(
  input  logic [3:0] mode_i,
  output prom_op_e   op_o
);
  // bit n of mode_i is mode pin n; unlisted codes fall back to inhibit
  always_comb begin
    unique casez (mode_i)
      4'b0101: op_o = OP_CLEAR;
      4'b1110: op_o = OP_WRITE;
      4'b1100: op_o = OP_VERIFY;
      default: op_o = OP_INHIBIT;
    endcase
  end
endmodule

// File: rtl/prom_addr_ctr.sv
module prom_addr_ctr #(
  parameter int unsigned DEPTH      = 1024,
  parameter int unsigned STEP_EDGES = 4,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned DIVW      = $clog2(STEP_EDGES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          x1_i,
  input  logic          clr_i,
  output logic [AW-1:0] addr_o,
  output logic          ovf_o
);
  localparam logic [AW-1:0]   LAST     = AW'(DEPTH - 1);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(STEP_EDGES - 1);

  logic            x1_q;
  logic            rise;
  logic [DIVW-1:0] div_q;
  logic [AW-1:0]   addr_q;
  logic            ovf_q;

  assign rise = x1_i & ~x1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q   <= 1'b0;
      div_q  <= '0;
      addr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      x1_q <= x1_i;
      if (clr_i) begin
        div_q  <= '0;
        addr_q <= '0;
        ovf_q  <= 1'b0;
      end else if (rise) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (addr_q == LAST) ovf_q  <= 1'b1;
          else                addr_q <= addr_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign addr_o = addr_q;
  assign ovf_o  = ovf_q;

  p_addr_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST);
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (addr_q == '0 && div_q == '0 && !ovf_q));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && rise && div_q == DIV_LAST && addr_q != LAST)
      |=> addr_q == $past(addr_q) + AW'(1));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !rise) |=> ($stable(addr_q) && $stable(div_q)));
  p_ovf_at_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> addr_q == LAST);
  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] cells_q [DEPTH];

  // cells only move from 1 toward 0; reset models the erased state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) cells_q[i] <= 8'hFF;
    end else if (we_i) begin
      cells_q[addr_i] <= cells_q[addr_i] & wdata_i;
    end
  end

  assign rdata_o = cells_q[addr_i];

  p_one_way_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(addr_i) |-> (rdata_o & ~$past(rdata_o)) == 8'h00);
  p_write_and_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_i) && $past(we_i)) |-> rdata_o == ($past(rdata_o) & $past(wdata_i)));
  p_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_i) && !$past(we_i)) |-> $stable(rdata_o));
endmodule

// File: rtl/prom_prog_ctrl.sv
module prom_prog_ctrl
  import prom_prog_pkg::*;
#(
  parameter int unsigned DEPTH      = 1024,
  parameter int unsigned STEP_EDGES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       x1_i,
  input  logic [3:0] mode_i,
  input  logic [3:0] dat_lo_i,
  input  logic [3:0] dat_hi_i,
  output logic [3:0] dat_lo_o,
  output logic [3:0] dat_hi_o,
  output logic       dat_oe_o,
  output logic       addr_ovf_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  prom_op_e      op;
  logic [AW-1:0] addr;
  logic [7:0]    rdata;
  logic [7:0]    wdata;
  logic          drive;

  prom_mode_dec u_dec (
    .mode_i (mode_i),
    .op_o   (op)
  );

  prom_addr_ctr #(.DEPTH(DEPTH), .STEP_EDGES(STEP_EDGES)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x1_i   (x1_i),
    .clr_i  (op == OP_CLEAR),
    .addr_o (addr),
    .ovf_o  (addr_ovf_o)
  );

  assign wdata = {dat_hi_i, dat_lo_i};

  prom_cell_array #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (op == OP_WRITE),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign drive    = (op == OP_VERIFY);
  assign dat_oe_o = drive;
  assign dat_lo_o = drive ? rdata[NIBBLE_W-1:0]      : '0;
  assign dat_hi_o = drive ? rdata[BYTE_W-1:NIBBLE_W] : '0;

  p_float_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_oe_o |-> (mode_i[1:0] == 2'b00 && mode_i[3:2] == 2'b11));
  p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_oe_o |-> (dat_lo_o == 4'h0 && dat_hi_o == 4'h0));
endmodule

// File: tb/prom_prog_ctrl_tb.sv
module prom_prog_ctrl_tb_top;
  localparam int DEPTH = 64;
  localparam int LAST  = DEPTH - 1;
  localparam logic [3:0] M_CLR = 4'b0101;
  localparam logic [3:0] M_WR  = 4'b1110;
  localparam logic [3:0] M_VFY = 4'b1100;
  localparam logic [3:0] M_INH = 4'b1111;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic x1 = 1'b0;
  logic [3:0] mode = M_INH;
  logic [3:0] dlo = '0, dhi = '0;
  logic [3:0] qlo, qhi;
  logic oe, ovf;

  always #5 clk = ~clk;

  prom_prog_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .x1_i(x1), .mode_i(mode),
    .dat_lo_i(dlo), .dat_hi_i(dhi), .dat_lo_o(qlo), .dat_hi_o(qhi),
    .dat_oe_o(oe), .addr_ovf_o(ovf));

  int vectors = 0, fails = 0, cycles = 0;
  logic [7:0] m_mem [DEPTH];
  int m_addr = 0, m_div = 0;
  logic m_ovf = 1'b0, m_x1 = 1'b0;

  function automatic int dec(input logic [3:0] md);
    if (md == M_CLR) return 1;
    if (md == M_WR)  return 2;
    if (md == M_VFY) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) ^ (a >> 2));
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
    end
  end

  task automatic cyc(input string tag, input logic [3:0] md, input logic xv, input logic [7:0] d);
    int op;
    logic exp_oe;
    logic [7:0] exp_d;
    @(negedge clk);
    mode = md; x1 = xv; dlo = d[3:0]; dhi = d[7:4];
    #1;
    op = dec(md);
    exp_oe = (op == 3);
    exp_d = exp_oe ? m_mem[m_addr] : 8'h00;
    vectors++;
    if (oe !== exp_oe || {qhi, qlo} !== exp_d || ovf !== m_ovf) begin
      fails++;
      $display("FAIL %s: actual oe=%b d=%h ovf=%b expected oe=%b d=%h ovf=%b",
               tag, oe, {qhi, qlo}, ovf, exp_oe, exp_d, m_ovf);
    end
    // next-state model: write uses pre-step address, clear beats step
    if (op == 2) m_mem[m_addr] = m_mem[m_addr] & d;
    if (op == 1) begin
      m_addr = 0; m_div = 0; m_ovf = 1'b0;
    end else if (xv && !m_x1) begin
      if (m_div == 3) begin
        m_div = 0;
        if (m_addr == LAST) m_ovf = 1'b1;
        else m_addr++;
      end else m_div++;
    end
    m_x1 = xv;
  endtask

  task automatic edges(input string tag, input logic [3:0] md, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(tag, md, 1'b1, 8'h00);
      cyc(tag, md, 1'b0, 8'h00);
    end
  endtask

  initial begin
    void'($urandom(32'd7919));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;

    // R1: reset state
    repeat (3) begin
      @(negedge clk); #1;
      vectors++;
      if (oe !== 1'b0 || {qhi, qlo} !== 8'h00 || ovf !== 1'b0) begin
        fails++;
        $display("FAIL R1 reset: actual oe=%b d=%h ovf=%b expected oe=0 d=00 ovf=0", oe, {qhi, qlo}, ovf);
      end
    end
    rst_ni = 1'b1;
    cyc("R1", M_VFY, 1'b0, 8'h00);
    cyc("R1", M_CLR, 1'b0, 8'h00);

    // R2/R8: every code, no edges, inputs carry zeros that must not land outside write
    for (int c = 0; c < 16; c++) cyc("R2 R8", 4'(c), 1'b0, 8'h00);
    cyc("R9", M_VFY, 1'b0, 8'h00);
    // R9: AND-only programming at address 0
    cyc("R9", M_WR, 1'b0, 8'hF0);
    cyc("R9", M_WR, 1'b0, 8'h3C);
    cyc("R9", M_WR, 1'b0, 8'hFF);
    cyc("R9", M_VFY, 1'b0, 8'h00);

    // R4/R5/R7: program every location, stepping past the top
    cyc("R3", M_CLR, 1'b0, 8'h00);
    for (int a = 0; a < DEPTH; a++) begin
      cyc("R7", M_WR, 1'b0, pat(a));
      cyc("R7", M_INH, 1'b0, 8'h00);
      edges("R4 R5", M_INH, 4);
    end
    edges("R5", M_VFY, 5);

    // R6/R4: verify walk
    cyc("R3", M_CLR, 1'b0, 8'h00);
    for (int a = 0; a < 20; a++) begin
      cyc("R6", M_VFY, 1'b0, 8'h00);
      edges("R4 R6", M_VFY, 4);
    end

    // R3: clear coincides with fourth edge
    edges("R3", M_VFY, 3);
    cyc("R3", M_CLR, 1'b1, 8'h00);
    cyc("R3", M_VFY, 1'b0, 8'h00);
    edges("R3", M_VFY, 3);
    edges("R3", M_VFY, 1);
    cyc("R3", M_VFY, 1'b0, 8'h00);

    // R7: write coincides with fourth edge
    edges("R7", M_INH, 3);
    cyc("R7", M_WR, 1'b1, 8'h81);
    cyc("R7", M_VFY, 1'b0, 8'h00);
    cyc("R7", M_CLR, 1'b0, 8'h00);
    edges("R7", M_VFY, 4);
    cyc("R7", M_VFY, 1'b0, 8'h00);

    // R8: inhibit variants with random data
    for (int i = 0; i < 16; i++) cyc("R8", {3'b111, 1'b1} & {3'b111, 1'($urandom)} | 4'b1101, 1'b0, 8'($urandom));
    cyc("R8", M_VFY, 1'b0, 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] md;
      r = int'($urandom % 100);
      if (r < 3)       md = M_CLR;
      else if (r < 10) md = M_WR;
      else if (r < 45) md = M_VFY;
      else if (r < 85) md = M_INH;
      else             md = 4'($urandom);
      cyc("R2 R4 R6 R7 R8", md, 1'($urandom), 8'($urandom | $urandom));
    end
    summary();
  end
endmodule